// File: doc/BRIEF.md
# Flash Memory Bus Interface Controller

This block models the bus-side behaviour of a byte-wide electrically erasable flash device. It watches three active-low control pins (chip select, output gate and write strobe), an address and a data byte, plus three level flags: programming supply high, high voltage present on address line 9, and core supply above the lockout level. From these it decides each cycle whether the device is idle, has its outputs disabled, is being read or is being written. It presents a read byte together with an output-enable flag that stands in for the tri-state drivers.

All pins are sampled on a system clock through a small synchronizer. Writes are recognised on the synchronized rising edge of the write strobe. They feed a command register that selects between array reads, identifier reads, a two-write program sequence, a two-write erase sequence and a verify state. The command register only responds while both supplies are good. Otherwise it is held at array read, so the contents cannot change. A separate high-voltage path on address line 9 returns the identifier codes whatever the command register holds. The storage is a small register array indexed by the low address bits.

Top module: `flash_bus_ctrl`

## Requirements
- R1: `dout_en` is high only while both `ce_n` and `oe_n` are low (after synchronization), and `dout` is 0x00 whenever `dout_en` is low.
- R2: While `ce_n` is high the block is idle: `dout_en` is low and pulses on `we_n` do not alter the command register or the array.
- R3: With `ce_n` low and `oe_n` high the outputs are disabled (`dout_en` low).
- R4: While `vpp_hi` is low the command register is held at array read and writes have no effect: a 0x90 write does not expose identifiers, a program sequence leaves the array unchanged, and a command written earlier is discarded once the supply drops.
- R5: While `a9_hv` is high, a read returns 0x89 when `addr[0]` is 0 and 0xBD when `addr[0]` is 1, whatever the other address bits, the supplies or the command register hold.
- R6: With both supplies good, writing 0x90 makes reads return the identifier codes of R5 selected by `addr[0]`, and writing 0x00 or 0xFF returns reads to array data.
- R7: While `vcc_ok` is low the command register behaves as in R4, even with `vpp_hi` high.
- R8: Writing 0x40 and then a data byte to an address sets the byte selected by `addr[3:0]` to its old value ANDed with the data, and the block enters verify, where reads return the addressed byte.
- R9: Writing 0x20 twice sets every array byte to 0xFF and enters verify; a second write other than 0x20 abandons the erase, leaves the array unchanged and returns to array read.
- R10: A write is taken only on the rising edge of `we_n` while `ce_n` is low and `oe_n` is high; a strobe with `oe_n` low is ignored.
- R11: Data values other than 0x00, 0x20, 0x40, 0x90 and 0xFF, written outside a setup state, leave the command register unchanged.
- R12: After reset the command register selects array read, every array byte is 0xFF and `dout_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output gate, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | 18 | Byte address |
| din | input | 8 | Write data / command byte |
| vpp_hi | input | 1 | Programming supply at high level |
| a9_hv | input | 1 | High voltage present on address line 9 |
| vcc_ok | input | 1 | Core supply above write lockout |
| dout | output | 8 | Read data (0x00 when not driven) |
| dout_en | output | 1 | Output drive enable (low means tri-stated) |

## Verification
Several properties are checked on every cycle. Chip deselect keeps the outputs off. An undriven bus reads zero. The high-voltage identifier path always returns the manufacturer code for an even address. A supply fault blocks program and erase strobes and puts the command register back to array read on the next cycle. A confirmed erase always lands in verify. Other behaviour shows up only over a sequence of bus cycles, and the bench's scenarios cover it: the AND result of a program, the erase abort, identifier mode entry and exit, unknown commands being ignored, and strobes with the output gate low being dropped.

// File: rtl/flash_bus_pkg.sv
package flash_bus_pkg;

    localparam int DATA_W = 8;

    // Command register states
    typedef enum logic [2:0] {
        CS_READ   = 3'd0,
        CS_IDENT  = 3'd1,
        CS_PSETUP = 3'd2,
        CS_ESETUP = 3'd3,
        CS_VERIFY = 3'd4
    } cmd_state_e;

    // Bus cycle classification
    typedef enum logic [1:0] {
        BM_IDLE   = 2'd0,
        BM_OUTDIS = 2'd1,
        BM_READ   = 2'd2,
        BM_WRITE  = 2'd3
    } bus_mode_e;

    // Synchronized pin bundle
    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
        logic vpp_hi;
        logic a9_hv;
        logic vcc_ok;
    } pin_vec_t;

    localparam int PIN_W = $bits(pin_vec_t);
    localparam pin_vec_t PIN_IDLE = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1,
                                      vpp_hi: 1'b0, a9_hv: 1'b0, vcc_ok: 1'b0};

    localparam logic [DATA_W-1:0] OP_READ   = 8'h00;
    localparam logic [DATA_W-1:0] OP_IDENT  = 8'h90;
    localparam logic [DATA_W-1:0] OP_PSETUP = 8'h40;
    localparam logic [DATA_W-1:0] OP_ESETUP = 8'h20;
    localparam logic [DATA_W-1:0] OP_ECONF  = 8'h20;
    localparam logic [DATA_W-1:0] OP_RESET  = 8'hFF;

    localparam logic [DATA_W-1:0] ID_MAKER  = 8'h89;
    localparam logic [DATA_W-1:0] ID_PART   = 8'hBD;
    localparam logic [DATA_W-1:0] BYTE_BLANK = 8'hFF;

    // Array write request carried from command logic to storage
    typedef struct packed {
        logic              prog;
        logic              erase;
        logic [DATA_W-1:0] data;
    } array_req_t;

    function automatic bus_mode_e classify(input logic ce_n, input logic oe_n,
                                           input logic we_n);
        if (ce_n)       return BM_IDLE;
        else if (!oe_n) return BM_READ;
        else if (!we_n) return BM_WRITE;
        else            return BM_OUTDIS;
    endfunction

    function automatic logic [DATA_W-1:0] ident_byte(input logic sel);
        return sel ? ID_PART : ID_MAKER;
    endfunction

endpackage

// File: rtl/flash_pin_sync.sv
module flash_pin_sync
    import flash_bus_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  pin_vec_t pins_in,
    output pin_vec_t pins_out
);
    pin_vec_t chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    chain[s] <= PIN_IDLE;
                end else if (s == 0) begin
                    chain[s] <= pins_in;
                end else begin
                    chain[s] <= chain[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign pins_out = chain[STAGES-1];
endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
    import flash_bus_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_en,
    input  logic              wr_evt,
    input  logic [DATA_W-1:0] wr_data,
    output cmd_state_e        state,
    output logic              prog_en,
    output logic              erase_en
);
    cmd_state_e next_state;

    always_comb begin
        next_state = state;
        case (state)
            CS_PSETUP: next_state = CS_VERIFY;
            CS_ESETUP: next_state = (wr_data == OP_ECONF) ? CS_VERIFY : CS_READ;
            default: begin
                case (wr_data)
                    OP_READ, OP_RESET: next_state = CS_READ;
                    OP_IDENT:          next_state = CS_IDENT;
                    OP_PSETUP:         next_state = CS_PSETUP;
                    OP_ESETUP:         next_state = CS_ESETUP;
                    default:           next_state = state;
                endcase
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= CS_READ;
        end else if (!cmd_en) begin
            state <= CS_READ;
        end else if (wr_evt) begin
            state <= next_state;
        end
    end

    assign prog_en  = cmd_en && wr_evt && (state == CS_PSETUP);
    assign erase_en = cmd_en && wr_evt && (state == CS_ESETUP) && (wr_data == OP_ECONF);
endmodule

// File: rtl/flash_array.sv
module flash_array
    import flash_bus_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  array_req_t        req,
    input  logic [AW-1:0]     wr_addr,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [DATA_W-1:0] mem [DEPTH];

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_byte
            always_ff @(posedge clk) begin
                if (rst || req.erase) begin
                    mem[i] <= BYTE_BLANK;
                end else if (req.prog && (wr_addr == AW'(i))) begin
                    mem[i] <= mem[i] & req.data;
                end
            end
        end
    endgenerate

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/flash_bus_ctrl.sv
module flash_bus_ctrl
    import flash_bus_pkg::*;
#(
    parameter int ADDR_W      = 18,
    parameter int ARR_AW      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    input  logic              vpp_hi,
    input  logic              a9_hv,
    input  logic              vcc_ok,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en
);
    pin_vec_t          pins_raw;
    pin_vec_t          pins_s;
    logic              we_prev;
    logic              we_rise;
    logic              wr_evt;
    logic              cmd_en;
    logic [ARR_AW-1:0] lat_addr;
    logic [DATA_W-1:0] lat_data;
    cmd_state_e        state;
    logic              prog_en;
    logic              erase_en;
    array_req_t        arr_req;
    logic [DATA_W-1:0] arr_rd;
    bus_mode_e         mode;
    logic              unused_addr_hi;

    assign unused_addr_hi = ^addr[ADDR_W-1:ARR_AW];

    assign pins_raw = '{ce_n: ce_n, oe_n: oe_n, we_n: we_n,
                        vpp_hi: vpp_hi, a9_hv: a9_hv, vcc_ok: vcc_ok};

    flash_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .pins_in  (pins_raw),
        .pins_out (pins_s)
    );

    // Write strobe edge detect and address/data capture while strobe is low
    always_ff @(posedge clk) begin
        if (rst) begin
            we_prev  <= 1'b1;
            lat_addr <= '0;
            lat_data <= '0;
        end else begin
            we_prev <= pins_s.we_n;
            if (!pins_s.we_n) begin
                lat_addr <= addr[ARR_AW-1:0];
                lat_data <= din;
            end
        end
    end

    assign we_rise = pins_s.we_n && !we_prev;
    assign wr_evt  = we_rise && !pins_s.ce_n && pins_s.oe_n;
    assign cmd_en  = pins_s.vpp_hi && pins_s.vcc_ok;

    flash_cmd_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .cmd_en   (cmd_en),
        .wr_evt   (wr_evt),
        .wr_data  (lat_data),
        .state    (state),
        .prog_en  (prog_en),
        .erase_en (erase_en)
    );

    assign arr_req = '{prog: prog_en, erase: erase_en, data: lat_data};

    flash_array #(.AW(ARR_AW)) u_arr (
        .clk     (clk),
        .rst     (rst),
        .req     (arr_req),
        .wr_addr (lat_addr),
        .rd_addr (addr[ARR_AW-1:0]),
        .rd_data (arr_rd)
    );

    // Read path: high-voltage identifier first, then command register
    assign mode    = classify(pins_s.ce_n, pins_s.oe_n, pins_s.we_n);
    assign dout_en = (mode == BM_READ);

    always_comb begin
        if (!dout_en) begin
            dout = '0;
        end else if (pins_s.a9_hv) begin
            dout = ident_byte(addr[0]);
        end else if (cmd_en && (state == CS_IDENT)) begin
            dout = ident_byte(addr[0]);
        end else begin
            dout = arr_rd;
        end
    end
endmodule

// File: rtl/flash_bus_ctrl_chk.sv
module flash_bus_ctrl_chk
    import flash_bus_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              ce_s,
    input logic              a9_s,
    input logic              addr0,
    input logic              cmd_en,
    input logic              wr_evt,
    input logic [DATA_W-1:0] wr_data,
    input cmd_state_e        state,
    input logic              prog_en,
    input logic              erase_en,
    input logic [DATA_W-1:0] dout,
    input logic              dout_en
);
    AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
        ce_s |-> !dout_en);                                                   // R2

    AST_UNDRIVEN_ZERO: assert property (@(posedge clk) disable iff (rst)
        !dout_en |-> (dout == 8'h00));                                        // R1

    AST_HV_MAKER_CODE: assert property (@(posedge clk) disable iff (rst)
        (dout_en && a9_s && !addr0) |-> (dout == 8'h89));                     // R5

    AST_LOCK_FORCES_READ: assert property (@(posedge clk) disable iff (rst)
        !cmd_en |=> (state == CS_READ));                                      // R4

    AST_LOCK_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
        !cmd_en |-> (!prog_en && !erase_en));                                 // R7

    AST_ERASE_TO_VERIFY: assert property (@(posedge clk) disable iff (rst)
        (cmd_en && wr_evt && state == CS_ESETUP && wr_data == 8'h20)
        |=> (state == CS_VERIFY));                                            // R9

    AST_PROG_ON_CONFIRM: assert property (@(posedge clk) disable iff (rst)
        (cmd_en && wr_evt && state == CS_PSETUP) |-> prog_en);                // R8
endmodule

bind flash_bus_ctrl flash_bus_ctrl_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .ce_s     (pins_s.ce_n),
    .a9_s     (pins_s.a9_hv),
    .addr0    (addr[0]),
    .cmd_en   (cmd_en),
    .wr_evt   (wr_evt),
    .wr_data  (lat_data),
    .state    (state),
    .prog_en  (prog_en),
    .erase_en (erase_en),
    .dout     (dout),
    .dout_en  (dout_en)
);

// File: tb/flash_bus_ctrl_tb.sv
module flash_bus_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [17:0] addr = '0;
    logic [7:0]  din = '0;
    logic        vpp_hi = 1'b0, a9_hv = 1'b0, vcc_ok = 1'b0;
    logic [7:0]  dout;
    logic        dout_en;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    flash_bus_ctrl u_dut (
        .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .din(din), .vpp_hi(vpp_hi), .a9_hv(a9_hv), .vcc_ok(vcc_ok),
        .dout(dout), .dout_en(dout_en)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [17:0] a, input logic [7:0] d,
                             input logic ce_lvl, input logic oe_lvl);
        @(negedge clk);
        addr = a; din = d; ce_n = ce_lvl; oe_n = oe_lvl;
        idle(3);
        we_n = 1'b0;
        idle(4);
        we_n = 1'b1;
        idle(4);
        ce_n = 1'b1; oe_n = 1'b1;
        idle(3);
    endtask

    task automatic wr(input logic [17:0] a, input logic [7:0] d);
        bus_write(a, d, 1'b0, 1'b1);
    endtask

    task automatic bus_read(input logic [17:0] a, output logic [7:0] d, output logic en);
        @(negedge clk);
        addr = a; we_n = 1'b1; ce_n = 1'b0; oe_n = 1'b0;
        idle(4);
        d = dout; en = dout_en;
        ce_n = 1'b1; oe_n = 1'b1;
        idle(3);
    endtask

    task automatic expect_read(input string req, input logic [17:0] a, input logic [7:0] exp);
        logic [7:0] d;
        logic en;
        bus_read(a, d, en);
        check(req, {7'd0, en}, 8'h01);
        check(req, d, exp);
    endtask

    task automatic supplies(input logic v, input logic c);
        @(negedge clk);
        vpp_hi = v; vcc_ok = c;
        idle(4);
    endtask

    task automatic t_reset();
        check("R12 dout_en after reset", {7'd0, dout_en}, 8'h00);
        check("R1 dout zero when idle", dout, 8'h00);
        expect_read("R12 array blank", 18'h00003, 8'hFF);
    endtask

    task automatic t_controls();
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b1; addr = 18'h1;
        idle(4);
        check("R3 output disabled", {7'd0, dout_en}, 8'h00);
        ce_n = 1'b1; oe_n = 1'b0;
        idle(4);
        check("R2 idle no drive", {7'd0, dout_en}, 8'h00);
        check("R1 undriven zero", dout, 8'h00);
        oe_n = 1'b1;
        idle(3);
    endtask

    task automatic t_program();
        supplies(1'b1, 1'b1);
        wr(18'h0, 8'h40);
        wr(18'h5, 8'hA5);
        expect_read("R8 verify after program", 18'h5, 8'hA5);
        wr(18'h0, 8'h40);
        wr(18'h5, 8'h3C);
        expect_read("R8 program ANDs", 18'h5, 8'h24);
        wr(18'h0, 8'h00);
        expect_read("R8 neighbour untouched", 18'h6, 8'hFF);
    endtask

    task automatic t_ident_cmd();
        wr(18'h0, 8'h90);
        expect_read("R6 maker code", 18'h0, 8'h89);
        expect_read("R6 part code", 18'h1, 8'hBD);
        wr(18'h0, 8'h55);
        expect_read("R11 unknown keeps ident", 18'h1, 8'hBD);
        wr(18'h0, 8'hFF);
        expect_read("R6 reset returns array", 18'h5, 8'h24);
        wr(18'h0, 8'h90);
        wr(18'h0, 8'h00);
        expect_read("R6 read cmd returns array", 18'h1, 8'hFF);
    endtask

    task automatic t_hv_ident();
        supplies(1'b0, 1'b1);
        @(negedge clk); a9_hv = 1'b1;
        expect_read("R5 hv maker high addr", 18'h20000, 8'h89);
        expect_read("R5 hv part", 18'h00005, 8'hBD);
        @(negedge clk); a9_hv = 1'b0;
        idle(3);
    endtask

    task automatic t_lockout();
        supplies(1'b0, 1'b1);
        wr(18'h0, 8'h40);
        wr(18'h2, 8'h00);
        expect_read("R4 program blocked", 18'h2, 8'hFF);
        wr(18'h0, 8'h90);
        expect_read("R4 ident cmd blocked", 18'h1, 8'hFF);
        supplies(1'b1, 1'b1);
        wr(18'h0, 8'h90);
        supplies(1'b0, 1'b1);
        supplies(1'b1, 1'b1);
        expect_read("R4 supply drop discards cmd", 18'h1, 8'hFF);
        supplies(1'b1, 1'b0);
        wr(18'h0, 8'h90);
        expect_read("R7 core lockout blocks ident", 18'h1, 8'hFF);
        wr(18'h0, 8'h40);
        wr(18'h3, 8'h0F);
        supplies(1'b1, 1'b1);
        expect_read("R7 core lockout blocks program", 18'h3, 8'hFF);
    endtask

    task automatic t_strobe_rules();
        bus_write(18'h0, 8'h40, 1'b1, 1'b1);
        bus_write(18'h7, 8'h00, 1'b1, 1'b1);
        expect_read("R2 deselected write ignored", 18'h7, 8'hFF);
        bus_write(18'h0, 8'h90, 1'b0, 1'b0);
        expect_read("R10 strobe with oe low ignored", 18'h1, 8'hFF);
    endtask

    task automatic t_erase();
        wr(18'h0, 8'h40);
        wr(18'h9, 8'h00);
        expect_read("R8 program second byte", 18'h9, 8'h00);
        wr(18'h0, 8'h20);
        wr(18'h0, 8'h30);
        expect_read("R9 aborted erase keeps data", 18'h9, 8'h00);
        wr(18'h0, 8'h20);
        wr(18'h0, 8'h20);
        expect_read("R9 erase blanks byte 9", 18'h9, 8'hFF);
        expect_read("R9 erase blanks byte 5", 18'h5, 8'hFF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        idle(3);
        t_reset();
        t_controls();
        t_program();
        t_ident_cmd();
        t_hv_ident();
        t_lockout();
        t_strobe_rules();
        t_erase();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule